// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block is a 32-pin general-purpose I/O peripheral behind a plain word-addressed register port. Software sets an output latch and a per-pin drive enable. It reads back the synchronized pad levels. It also sets up each pin as an interrupt source.

Every pin has a 2-bit trigger code that selects one of four conditions: level low, level high, rising edge or falling edge. A separate per-pin both-edges bit overrides that code. A detected condition sets a sticky status bit. Software clears a status bit by writing a one to it. Masked status drives two interrupt lines, one for the lower half of the pins and one for the upper half.

Each pad appears as three separate vectors: output value, output enable and input. The reset input is asserted asynchronously and is released through an internal two-flop synchronizer. Register writes take effect on the clock edge where `wr_en` is high. Read data appears on the edge after `rd_en` is sampled high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Word addresses select the registers as follows:
  - 0: output latch
  - 1: drive enable
  - 2: pad level (read-only)
  - 3: trigger codes for pins 0–15
  - 4: trigger codes for pins 16–31
  - 5: interrupt mask
  - 6: interrupt status
  - 7: both-edges select

  After reset, every writable register and all status bits are zero, and `rdata` returns the value of the addressed register one clock after `rd_en`.
- R2: `pad_oe` equals the drive-enable register and `pad_out` equals the output latch, one clock after the write.
- R3: Reading address 2 returns `pad_in` delayed by the two-flop synchronizer, even for pins whose drive enable is set. Writes to address 2 change nothing.
- R4: The trigger code of pin n is 2 bits wide. Pin n below 16 takes bits [2n+1:2n] of word 3, and pin n of 16 or above takes bits [2(n-16)+1:2(n-16)] of word 4. The codes are: 0 level low, 1 level high, 2 rising edge, 3 falling edge.
- R5: When a pin's bit in word 7 is 1, any change of its synchronized level sets its status bit, and its trigger code has no effect.
- R6: Writing word 6 clears each status bit written with 1 and leaves each bit written with 0 unchanged.
- R7: A level condition sets its status bit on every clock it holds. If a set and a clear hit the same bit on the same clock, the bit ends up set.
- R8: `irq_lo` is the OR of status AND mask over pins 0–15, and `irq_hi` is the same over pins 16–31. Both are low while the corresponding mask bits are zero.
- R9: A change on `pad_in` applied between two clock edges shows in the status bit on the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad drive enables |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
The trigger logic is swept over every uniform trigger code, over the all-pins both-edges setting, and over a mixed setting where the code varies per pin and the override is set on scattered pins in both halves. Each setting is tried with pin-pair patterns: all-low to all-high, high to low, alternating bits, and an irregular mix. These patterns separate the rising, falling and level conditions pin by pin, and show which config word each pin reads. A clear issued while a level still holds shows the set-wins rule. A partial clear on edge-latched bits shows that zeros in the write leave bits untouched. Half-masks show which interrupt line each pin feeds, and a single pin change timed against the interrupt line fixes the three-edge latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    TRIG_LEVEL_LO = 2'd0,
    TRIG_LEVEL_HI = 2'd1,
    TRIG_RISE     = 2'd2,
    TRIG_FALL     = 2'd3
  } trig_e;

  localparam logic [ADDR_W-1:0] REG_OUT    = 3'd0;
  localparam logic [ADDR_W-1:0] REG_DIR    = 3'd1;
  localparam logic [ADDR_W-1:0] REG_LEVEL  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_TRIGLO = 3'd3;
  localparam logic [ADDR_W-1:0] REG_TRIGHI = 3'd4;
  localparam logic [ADDR_W-1:0] REG_MASK   = 3'd5;
  localparam logic [ADDR_W-1:0] REG_STAT   = 3'd6;
  localparam logic [ADDR_W-1:0] REG_ANYEDG = 3'd7;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl      = lvl_q;
  assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] lvl_prev,
  input  logic [NPINS-1:0] trig_lo,
  input  logic [NPINS-1:0] trig_hi,
  input  logic [NPINS-1:0] any_edge,
  output logic [NPINS-1:0] hit
);
  localparam int HALF = NPINS / 2;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int SH = 2 * (p % HALF);
    trig_e code;
    logic  rise, fall;

    assign code = trig_e'((p < HALF) ? trig_lo[SH +: 2] : trig_hi[SH +: 2]);
    assign rise = lvl[p] & ~lvl_prev[p];
    assign fall = ~lvl[p] & lvl_prev[p];

    always_comb begin
      if (any_edge[p]) begin
        hit[p] = rise | fall;
      end else begin
        case (code)
          TRIG_LEVEL_LO: hit[p] = ~lvl[p];
          TRIG_LEVEL_HI: hit[p] = lvl[p];
          TRIG_RISE:     hit[p] = rise;
          default:       hit[p] = fall;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  lvl,
  input  logic [NPINS-1:0]  hit,
  output logic [NPINS-1:0]  rdata,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  trig_lo_q,
  output logic [NPINS-1:0]  trig_hi_q,
  output logic [NPINS-1:0]  mask_q,
  output logic [NPINS-1:0]  st_q,
  output logic [NPINS-1:0]  any_q
);
  logic [NPINS-1:0] out_d, dir_d, tlo_d, thi_d, mask_d, st_d, any_d, rd_d, rd_q;
  logic [NPINS-1:0] clr_bits;

  always_comb begin
    out_d  = out_q;
    dir_d  = dir_q;
    tlo_d  = trig_lo_q;
    thi_d  = trig_hi_q;
    mask_d = mask_q;
    any_d  = any_q;
    clr_bits = '0;
    if (wr_en) begin
      case (addr)
        REG_OUT:    out_d  = wdata;
        REG_DIR:    dir_d  = wdata;
        REG_TRIGLO: tlo_d  = wdata;
        REG_TRIGHI: thi_d  = wdata;
        REG_MASK:   mask_d = wdata;
        REG_STAT:   clr_bits = wdata;
        REG_ANYEDG: any_d  = wdata;
        default:    ;
      endcase
    end
    st_d = (st_q & ~clr_bits) | hit;
  end

  always_comb begin
    case (addr)
      REG_OUT:    rd_d = out_q;
      REG_DIR:    rd_d = dir_q;
      REG_LEVEL:  rd_d = lvl;
      REG_TRIGLO: rd_d = trig_lo_q;
      REG_TRIGHI: rd_d = trig_hi_q;
      REG_MASK:   rd_d = mask_q;
      REG_STAT:   rd_d = st_q;
      default:    rd_d = any_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q     <= '0;
      dir_q     <= '0;
      trig_lo_q <= '0;
      trig_hi_q <= '0;
      mask_q    <= '0;
      st_q      <= '0;
      any_q     <= '0;
      rd_q      <= '0;
    end else begin
      out_q     <= out_d;
      dir_q     <= dir_d;
      trig_lo_q <= tlo_d;
      trig_hi_q <= thi_d;
      mask_q    <= mask_d;
      st_q      <= st_d;
      any_q     <= any_d;
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = NPINS / 2;

  logic             rst_meta_q, rst_sync_n;
  logic [NPINS-1:0] lvl, lvl_prev, hit;
  logic [NPINS-1:0] out_q, dir_q, trig_lo_q, trig_hi_q, mask_q, st_q, any_q;
  logic [NPINS-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .pad_in(pad_in),
    .lvl(lvl), .lvl_prev(lvl_prev)
  );

  gpio_trig #(.NPINS(NPINS)) u_trig (
    .lvl(lvl), .lvl_prev(lvl_prev), .trig_lo(trig_lo_q), .trig_hi(trig_hi_q),
    .any_edge(any_q), .hit(hit)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .lvl(lvl), .hit(hit), .rdata(rdata),
    .out_q(out_q), .dir_q(dir_q), .trig_lo_q(trig_lo_q), .trig_hi_q(trig_hi_q),
    .mask_q(mask_q), .st_q(st_q), .any_q(any_q)
  );

  assign pend    = st_q & mask_q;
  assign irq_lo  = |pend[HALF-1:0];
  assign irq_hi  = |pend[NPINS-1:HALF];
  assign pad_out = out_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NPINS-1:0]  wdata,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  st,
  input logic [NPINS-1:0]  hit,
  input logic [NPINS-1:0]  mask,
  input logic              irq_lo,
  input logic              irq_hi
);
  localparam int HALF = NPINS / 2;

  // R2
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_DIR) |=> (pad_oe == $past(wdata)));

  // R2
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_OUT) |=> (pad_out == $past(wdata)));

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_STAT) |=> ((st & $past(wdata & ~hit)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((~st & $past(hit)) == '0));

  // R5
  st_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st & ~$past(st) & ~$past(hit)) == '0));

  // R8
  irq_lo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[HALF-1:0] == '0) |-> !irq_lo);

  // R8
  irq_hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[NPINS-1:HALF] == '0) |-> !irq_hi);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .pad_oe(pad_oe), .pad_out(pad_out), .st(st_q), .hit(hit), .mask(mask_q),
  .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata, pad_in, pad_out, pad_oe;
  logic        irq_lo, irq_hi;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  gpio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] expect_st(logic [31:0] tl, logic [31:0] th,
                                            logic [31:0] ae, logic [31:0] a,
                                            logic [31:0] b);
    logic [31:0] e;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] c;
      c = (i < 16) ? tl[2*i +: 2] : th[2*(i-16) +: 2];
      if (ae[i]) e[i] = a[i] ^ b[i];
      else case (c)
        2'd0: e[i] = ~a[i] | ~b[i];
        2'd1: e[i] = a[i] | b[i];
        2'd2: e[i] = ~a[i] & b[i];
        default: e[i] = a[i] & ~b[i];
      endcase
    end
    return e;
  endfunction

  // R4 R5 R6 R7 R8: configure, settle at a, clear, move to b, read status, check irqs
  task automatic sweep(string req, logic [31:0] tl, logic [31:0] th,
                       logic [31:0] ae, logic [31:0] a, logic [31:0] b,
                       logic [31:0] m);
    logic [31:0] got, e;
    wr(3'd5, 32'h0);
    wr(3'd3, tl);
    wr(3'd4, th);
    wr(3'd7, ae);
    @(negedge clk); pad_in = a;
    settle();
    wr(3'd6, 32'hFFFF_FFFF);
    pad_in = b;
    settle();
    rd(3'd6, got);
    e = expect_st(tl, th, ae, a, b);
    check(req, got, e);
    wr(3'd5, m);
    check({req, " R8 irq_lo"}, {31'd0, irq_lo}, {31'd0, |(e[15:0] & m[15:0])});
    check({req, " R8 irq_hi"}, {31'd0, irq_hi}, {31'd0, |(e[31:16] & m[31:16])});
  endtask

  initial begin
    logic [31:0] pa [4];
    logic [31:0] pb [4];
    logic [31:0] got;
    pa[0] = 32'h0000_0000; pb[0] = 32'hFFFF_FFFF;
    pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0000;
    pa[2] = 32'h5555_AAAA; pb[2] = 32'hAAAA_AAAA;
    pa[3] = 32'h1234_8000; pb[3] = 32'h9C3A_0001;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 pad_oe reset", pad_oe, 32'h0);
    check("R1 pad_out reset", pad_out, 32'h0);
    check("R8 irq reset", {30'd0, irq_hi, irq_lo}, 32'h0);
    rd(3'd0, got); check("R1 out reg reset", got, 32'h0);
    rd(3'd1, got); check("R1 dir reg reset", got, 32'h0);
    rd(3'd5, got); check("R1 mask reset", got, 32'h0);
    rd(3'd7, got); check("R1 anyedge reset", got, 32'h0);

    // R2 drive path
    wr(3'd0, 32'hA5A5_0F0F);
    check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    wr(3'd1, 32'h0000_FFFF);
    check("R2 pad_oe", pad_oe, 32'h0000_FFFF);
    rd(3'd0, got); check("R1 out readback", got, 32'hA5A5_0F0F);
    rd(3'd1, got); check("R1 dir readback", got, 32'h0000_FFFF);

    // R3 pad level, including driven pins, and write ignored
    @(negedge clk); pad_in = 32'h1234_5678;
    settle();
    rd(3'd2, got); check("R3 pad level", got, 32'h1234_5678);
    wr(3'd2, 32'hDEAD_BEEF);
    rd(3'd2, got); check("R3 write ignored", got, 32'h1234_5678);
    check("R3 write ignored out", pad_out, 32'hA5A5_0F0F);

    // R4 uniform codes over all pins
    for (int c = 0; c < 4; c++) begin
      logic [31:0] w;
      w = {16{c[1:0]}};
      for (int p = 0; p < 4; p++)
        sweep($sformatf("R4 code%0d pat%0d", c, p), w, w, 32'h0, pa[p], pb[p],
              (p % 2 == 0) ? 32'h0000_FFFF : 32'hFFFF_0000);
    end
    // R5 both-edge override over rising codes
    for (int p = 0; p < 4; p++)
      sweep($sformatf("R5 anyedge pat%0d", p), 32'hAAAA_AAAA, 32'hAAAA_AAAA,
            32'hFFFF_FFFF, pa[p], pb[p], 32'hFFFF_FFFF);
    // R4 R5 mixed per-pin codes and scattered overrides
    for (int p = 0; p < 4; p++)
      sweep($sformatf("R4 R5 mixed pat%0d", p), 32'hE4E4_1B1B, 32'h4E4E_B1B1,
            32'h00F0_0F00, pa[p], pb[p], 32'h0F0F_F0F0);

    // R6 partial clear of edge-latched bits
    sweep("R6 setup", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0);
    wr(3'd6, 32'h0F0F_0F0F);
    rd(3'd6, got); check("R6 w1c partial", got, 32'hF0F0_F0F0);
    wr(3'd6, 32'h0000_0000);
    rd(3'd6, got); check("R6 zero write", got, 32'hF0F0_F0F0);

    // R7 level held: clear loses
    sweep("R7 setup", 32'h5555_5555, 32'h5555_5555, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, got); check("R7 set wins", got, 32'hFFFF_FFFF);

    // R9 latency: rising code on pin 3, mask only pin 3
    wr(3'd5, 32'h0);
    wr(3'd7, 32'h0);
    wr(3'd3, 32'hAAAA_AAAA);
    @(negedge clk); pad_in = 32'h0;
    settle();
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd5, 32'h0000_0008);
    pad_in = 32'h0000_0008;
    @(negedge clk); @(negedge clk);
    check("R9 not yet", {31'd0, irq_lo}, 32'h0);
    @(negedge clk);
    check("R9 third edge", {31'd0, irq_lo}, 32'h1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule